// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the modem status byte of an 8250-style serial port. Four modem lines (clear-to-send, data-set-ready, ring indicator, data-carrier-detect) are followed continuously. When they change, sticky change bits are set and a modem-status interrupt source is raised. A host read of the status byte returns the value presented in that cycle, and the following clock edge clears the change bits and the interrupt source. A host write loads the whole byte directly.

In normal operation the four lines come from pins outside the block. Each passes through a flop synchroniser before any change detection. When the loopback bit of the modem control value is set, the pins are ignored. The four modem control outputs are routed onto the status lines inside the block instead, so software can exercise the full status path without outside wiring. After reset a short priming window loads the held line state from the inputs, so power-up levels do not raise false change bits.

Top module: `modem_stat_lb`

## Requirements
- R1: While reset is asserted, `stat_q` is 0x00 and `ms_irq` is 0.
- R2: Status bit layout: bit4 CTS, bit5 DSR, bit6 RI and bit7 DCD show the held line state. Bit0 is the CTS change, bit1 the DSR change, bit2 the RI trailing edge and bit3 the DCD change.
- R3: When `ctl_word[4]` is 1, the lines are taken from the control value: CTS from `ctl_word[1]`, DSR from `ctl_word[0]`, RI from `ctl_word[2]` and DCD from `ctl_word[3]`. The external pins then have no effect. In loopback the held state follows a control change after one clock edge.
- R4: Bits 0, 1 and 3 are set when the held CTS, DSR or DCD state differs from the new line state, in either direction.
- R5: Bit2 is set only when RI goes from 1 to 0. A 0-to-1 change of RI sets no change bit.
- R6: Change bits stay set until a read or a write, even when the line returns to its former level.
- R7: When `stat_rd` is high, `stat_q` in that cycle is the value read. At the next edge bits 3:0 and `ms_irq` clear and bits 7:4 are kept. A change detected at that same edge is still recorded.
- R8: When `host_wr` is high, the next edge loads `host_wdata` into all eight bits, ahead of any read or detection in that cycle. `ms_irq` is set if `host_wdata[3:0]` is nonzero and is left unchanged otherwise.
- R9: `ms_irq` is set at every edge that records a new change bit, and it is high whenever any of bits 3:0 is set.
- R10: Outside loopback, a change on an external pin reaches the status byte SYNC_STAGES+1 edges later (three with the default), and not earlier.
- R11: During the first SYNC_STAGES+1 edges after reset, the held state is loaded from the line source and no change bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 5 | Low five bits of the modem control value (bit4 loopback) |
| ext_cts | input | 1 | External clear-to-send pin |
| ext_dsr | input | 1 | External data-set-ready pin |
| ext_ri | input | 1 | External ring-indicator pin |
| ext_dcd | input | 1 | External carrier-detect pin |
| stat_rd | input | 1 | Host read strobe for the status byte |
| host_wr | input | 1 | Host write strobe for the status byte |
| host_wdata | input | 8 | Host write data |
| stat_q | output | 8 | Modem status byte |
| ms_irq | output | 1 | Modem-status interrupt source |

## Verification
Directed patterns cover the following cases:
- A single pin step, which separates the synchroniser delay from the detection edge.
- A ring line rising and then falling, which separates leading-edge from trailing-edge reporting.
- A carrier pulse that returns to its old level, which shows that change bits are sticky.
- A read landing on the same edge as a new change.
- Loopback control patterns with conflicting pin values, which show the line routing and that the pins are ignored.
- Host writes with zero and nonzero low nibbles, which show how the interrupt source is updated.

A long random mix of pin noise, loopback toggling, reads and writes is then compared cycle by cycle against a bench model. The model exposes ordering errors between write, read and detection.

// File: rtl/msl_pkg.sv
package msl_pkg;

  // Line vector in the order of the status upper nibble.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  localparam int unsigned LOOP_BIT = 4;

  // Loopback routing of control outputs onto status lines.
  function automatic mline_t loop_route(input logic [3:0] ctl);
    mline_t r;
    r.cts = ctl[1];
    r.dsr = ctl[0];
    r.ri  = ctl[2];
    r.dcd = ctl[3];
    return r;
  endfunction

  // Change flags between held and new line state.
  function automatic logic [3:0] edge_flags(input mline_t held, input mline_t now);
    logic [3:0] d;
    d[0] = held.cts ^ now.cts;
    d[1] = held.dsr ^ now.dsr;
    d[2] = held.ri & ~now.ri;
    d[3] = held.dcd ^ now.dcd;
    return d;
  endfunction

endpackage

// File: rtl/msl_sync.sv
module msl_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/msl_src_sel.sv
module msl_src_sel
  import msl_pkg::*;
(
  input  logic [4:0] ctl,
  input  mline_t     ext_sync,
  output mline_t     line,
  output logic       loop_on
);
  assign loop_on = ctl[LOOP_BIT];
  assign line    = loop_on ? loop_route(ctl[3:0]) : ext_sync;
endmodule

// File: rtl/msl_stat_core.sv
module msl_stat_core
  import msl_pkg::*;
#(
  parameter int unsigned WARM_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mline_t     line,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wd,
  output logic [7:0] status,
  output logic       irq,
  output logic       chg_any,
  output logic       primed
);
  localparam int unsigned CW = $clog2(WARM_CYC + 1);

  logic [3:0]    held_q;
  logic [3:0]    dlt_q;
  logic          irq_q;
  logic [CW-1:0] warm_q;
  logic [3:0]    new_d;

  assign primed  = (warm_q == CW'(WARM_CYC));
  assign new_d   = primed ? edge_flags(mline_t'(held_q), line) : 4'b0000;
  assign chg_any = |new_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      dlt_q  <= '0;
      irq_q  <= 1'b0;
      warm_q <= '0;
    end else begin
      if (!primed) warm_q <= warm_q + 1'b1;
      if (wr) begin
        held_q <= wd[7:4];
        dlt_q  <= wd[3:0];
        if (|wd[3:0]) irq_q <= 1'b1;
      end else begin
        held_q <= line;
        dlt_q  <= (rd ? 4'b0000 : dlt_q) | new_d;
        irq_q  <= (rd ? 1'b0 : irq_q) | chg_any;
      end
    end
  end

  assign status = {held_q, dlt_q};
  assign irq    = irq_q;
endmodule

// File: rtl/modem_stat_lb.sv
module modem_stat_lb
  import msl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ctl_word,
  input  logic       ext_cts,
  input  logic       ext_dsr,
  input  logic       ext_ri,
  input  logic       ext_dcd,
  input  logic       stat_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] stat_q,
  output logic       ms_irq
);
  localparam int unsigned WARM_CYC = SYNC_STAGES + 1;

  mline_t ext_raw;
  mline_t ext_sync;
  mline_t line_src;
  logic   loop_on;
  logic   chg_any;
  logic   primed;

  assign ext_raw = '{dcd: ext_dcd, ri: ext_ri, dsr: ext_dsr, cts: ext_cts};

  msl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ext_raw),
    .d_out (ext_sync)
  );

  msl_src_sel u_sel (
    .ctl      (ctl_word),
    .ext_sync (ext_sync),
    .line     (line_src),
    .loop_on  (loop_on)
  );

  msl_stat_core #(.WARM_CYC(WARM_CYC)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .line    (line_src),
    .rd      (stat_rd),
    .wr      (host_wr),
    .wd      (host_wdata),
    .status  (stat_q),
    .irq     (ms_irq),
    .chg_any (chg_any),
    .primed  (primed)
  );
endmodule

// File: rtl/msl_checker.sv
module msl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ctl_word,
  input logic       stat_rd,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] stat_q,
  input logic       ms_irq,
  input logic       chg_any,
  input logic       primed
);
  // R9: any pending change bit implies the interrupt source
  a_r9_flag_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q[3:0]) |-> ms_irq);

  // R7: a read with no new change clears the low nibble and the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !host_wr && !chg_any) |=> (stat_q[3:0] == 4'b0000) && !ms_irq);

  // R6: without read or write no change bit is lost
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !host_wr) |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  // R8: a write loads the full byte
  a_r8_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> stat_q == $past(host_wdata));

  // R3: loopback routing of control bits onto the upper nibble
  a_r3_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word[4] && !host_wr) |=>
      stat_q[7:4] == $past({ctl_word[3], ctl_word[2], ctl_word[0], ctl_word[1]}));

  // R5: the ring bit rises only on a trailing edge of RI
  a_r5_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[2]) && !$past(host_wr)) |-> ($past(stat_q[6]) && !stat_q[6]));

  // R11: no change is raised before priming completes
  a_r11_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !chg_any);
endmodule

bind modem_stat_lb msl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_word   (ctl_word),
  .stat_rd    (stat_rd),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .stat_q     (stat_q),
  .ms_irq     (ms_irq),
  .chg_any    (chg_any),
  .primed     (primed)
);

// File: tb/sim_modem_stat_lb.sv
module sim_modem_stat_lb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ctl;
  logic [3:0] ev;          // [0] cts [1] dsr [2] ri [3] dcd
  logic       rd, wr;
  logic [7:0] wd;
  logic [7:0] stat_q;
  logic       ms_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  modem_stat_lb u0 (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl),
    .ext_cts(ev[0]), .ext_dsr(ev[1]), .ext_ri(ev[2]), .ext_dcd(ev[3]),
    .stat_rd(rd), .host_wr(wr), .host_wdata(wd),
    .stat_q(stat_q), .ms_irq(ms_irq)
  );

  // Bench model built from the requirements
  logic [3:0] m_s0, m_s1, m_hi, m_lo;
  logic       m_fl;
  int         m_warm;

  function automatic logic [3:0] lp(input logic [4:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  function automatic logic [3:0] dmask(input logic [3:0] h, input logic [3:0] n);
    logic [3:0] d;
    for (int i = 0; i < 4; i++)
      d[i] = (i == 2) ? (h[i] && !n[i]) : (h[i] != n[i]);
    return d;
  endfunction

  always @(posedge clk) begin
    logic [3:0] cur, nd;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_hi = 0; m_lo = 0; m_fl = 0; m_warm = 0;
    end else begin
      cur = ctl[4] ? lp(ctl) : m_s1;
      if (wr) begin
        m_hi = wd[7:4]; m_lo = wd[3:0];
        if (wd[3:0] != 0) m_fl = 1;
      end else begin
        nd = (m_warm < 3) ? 4'b0 : dmask(m_hi, cur);
        if (rd) begin m_lo = 0; m_fl = 0; end
        m_lo = m_lo | nd;
        if (nd != 0) m_fl = 1;
        m_hi = cur;
      end
      if (m_warm < 3) m_warm++;
      m_s1 = m_s0; m_s0 = ev;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; ctl = 0; ev = 0; rd = 0; wr = 0; wd = 0;
    @(negedge clk);
    tick(3);
    chk("R1 reset status", stat_q, 8'h00);
    chk("R1 reset irq", {7'b0, ms_irq}, 8'h00);
    ev = 4'b0110;
    rst_n = 1;
    tick(5);
    chk("R11 primed no delta", stat_q, 8'h60);
    chk("R11 primed irq", {7'b0, ms_irq}, 8'h00);

    ev[0] = 1'b1;
    tick(2);
    chk("R10 not yet visible", stat_q, 8'h60);
    tick(1);
    chk("R4 R2 cts change", stat_q, 8'h71);
    chk("R9 irq on change", {7'b0, ms_irq}, 8'h01);

    rd = 1;
    chk("R7 read value", stat_q, 8'h71);
    tick(1); rd = 0;
    chk("R7 read clears", stat_q, 8'h70);
    chk("R7 irq cleared", {7'b0, ms_irq}, 8'h00);

    ev[2] = 1'b0;
    tick(3);
    chk("R5 ri trailing", stat_q, 8'h34);
    rd = 1; tick(1); rd = 0;
    ev[2] = 1'b1;
    tick(3);
    chk("R5 ri leading ignored", stat_q, 8'h70);
    chk("R5 no irq", {7'b0, ms_irq}, 8'h00);

    ev[3] = 1'b1; tick(3);
    ev[3] = 1'b0; tick(3);
    chk("R6 sticky dcd", stat_q, 8'h78);
    rd = 1; tick(1); rd = 0;

    ev[0] = 1'b0;
    tick(2);
    rd = 1; tick(1); rd = 0;
    chk("R7 change wins over read", stat_q, 8'h61);
    chk("R7 irq kept", {7'b0, ms_irq}, 8'h01);
    rd = 1; tick(1); rd = 0;

    ctl = 5'h12;
    tick(1);
    chk("R3 loop rts to cts", stat_q, 8'h17);
    rd = 1; tick(1); rd = 0;
    chk("R3 after read", stat_q, 8'h10);
    ctl = 5'h1D; ev = 4'b0001;
    tick(1);
    chk("R3 loop dtr out1 out2", stat_q, 8'hEB);
    tick(3);
    chk("R3 pins ignored", stat_q, 8'hEB);
    rd = 1; tick(1); rd = 0;
    chk("R7 clear in loop", stat_q, 8'hE0);

    wr = 1; wd = 8'h50; tick(1);
    chk("R8 write load", stat_q, 8'h50);
    chk("R8 zero nibble no irq", {7'b0, ms_irq}, 8'h00);
    wd = 8'h0C; tick(1);
    chk("R8 write deltas", stat_q, 8'h0C);
    chk("R8 irq set", {7'b0, ms_irq}, 8'h01);
    wd = 8'h00; tick(1);
    chk("R8 irq unchanged", {7'b0, ms_irq}, 8'h01);
    wr = 0; ctl = 0;
    tick(4);

    for (int k = 0; k < 3000; k++) begin
      chk("R4 R9 random status", stat_q, {m_hi, m_lo});
      chk("R9 random irq", {7'b0, ms_irq}, {7'b0, m_fl});
      ev  = 4'($urandom);
      ctl = 5'($urandom);
      rd  = ($urandom % 4) == 0;
      wr  = ($urandom % 16) == 0;
      wd  = 8'($urandom);
      @(posedge clk); @(negedge clk);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule